// File: doc/BRIEF.md
# Two-Wire Register Slave with Write-Enable Latch

This block is a slave on a two-wire serial bus. It runs on a fast system clock that oversamples the SCL and SDA lines, and it pulls SDA low through an open-drain output enable. Two byte registers sit behind the bus. The first is a read-only status byte that shows three gate status inputs and a write-enable latch. The second is a shutdown byte. The low two bits of the shutdown byte go out as an override code to a power sequencer next to this block.

A master addresses the slave with a byte made of a fixed type code, three select bits that must equal the strap pins, and a direction bit. It then sends a word address that picks the register. A write carries one data byte. A read is a dummy write of the word address, followed by a repeated start with the direction bit set; the slave then returns one byte. The shutdown byte accepts a write only after the latch has been set by writing the key value 01h to the status byte. If the latch is clear, the slave refuses the data byte with a NACK and discards it.

Top module: `tw_regslave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Before a start the slave drives nothing and acknowledges nothing.
- R2: The address byte, sent MSB first, is type code 1010 in bits 7..4, select bits in bits 3..1 and the direction bit in bit 0 (1 = read). The slave acknowledges only when the type code matches and the select bits equal `strap_addr`. Otherwise it leaves SDA released for the rest of the frame.
- R3: After a matching address, the slave acknowledges the word address byte. It also acknowledges every data byte, except the case in R7.
- R4: Word address 00h selects the status byte and FFh selects the shutdown byte. The status byte reads as {4'b0000, gate_stat[2], gate_stat[1], gate_stat[0], latch}, where gate_stat[2] is the primary gate status, gate_stat[1] the I/O gate status and gate_stat[0] the core gate status.
- R5: The latch is clear after reset. Writing exactly 01h to the status byte sets it.
- R6: A status-byte write of any value other than 01h is acknowledged and changes nothing. Only reset clears the latch.
- R7: While the latch is clear, a data byte written to the shutdown byte gets a NACK, and `shut_code` keeps its value.
- R8: While the latch is set, a write to the shutdown byte is acknowledged and loads data bits 1..0 into `shut_code`. A read of the shutdown byte returns bits 7..2 as zero.
- R9: A random read returns one byte, MSB first. The master then sends a NACK and a stop, and the slave releases SDA.
- R10: The slave starts driving SDA low only while SCL is low, and it releases SDA after the ninth clock of every byte.
- R11: After reset, `shut_code` is 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_addr | input | 3 | Select bits compared with address bits 3..1 |
| gate_stat | input | 3 | Gate status: [2] primary, [1] I/O, [0] core |
| shut_code | output | 2 | Override code held in the shutdown byte |

## Verification
The address check is swept over all 64 pairs of strap value and select bits, plus a wrong type code and clocked traffic with no start. This separates matching from mismatching frames, and also checks that frames with no start are ignored. Status reads are swept over all eight gate patterns, so the position of each status bit is checked on its own. Shutdown writes are tried with the latch clear, to confirm the NACK and that nothing changes, and with the latch set, using all four codes with junk in the upper bits. Status writes of non-key values are sent both before and after the latch is set, and a monitor watches that SDA drive never begins while SCL is high.

// File: rtl/tw_pkg.sv
// Shared types and constants for the two-wire register slave.
// Assumes 8-bit bytes and one data byte per transfer.
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam logic [BYTE_W-1:0] WA_STATUS = 8'h00;
    localparam logic [BYTE_W-1:0] WA_SHUT   = 8'hFF;
    localparam logic [BYTE_W-1:0] LATCH_KEY = 8'h01;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DEV, PH_WORD, PH_WDATA, PH_RDATA
    } phase_t;

    typedef enum logic [1:0] {
        SEL_NONE, SEL_STAT, SEL_SHUT
    } sel_t;
endpackage

// File: rtl/tw_sync.sv
// Multi-stage synchronizer for the bus lines.
// Assumes the idle bus level is high, so reset loads ones.
module tw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift one stage of the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '1;
            else if (g == 0) chain[g] <= d;
            else chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_regs.sv
// Status and shutdown byte registers with the write-enable latch.
// Assumes one write strobe per accepted data byte. The bus engine
// has already refused shutdown writes while the latch is clear.
module tw_regs
    import tw_pkg::*;
#(
    parameter int GATE_W = 3,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GATE_W-1:0] gate_stat,
    input  logic              wr_stb,
    input  sel_t              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] shut_byte,
    output logic              wel,
    output logic [CODE_W-1:0] shut_code
);
    localparam int STAT_PAD = BYTE_W - GATE_W - 1;
    localparam int SHUT_PAD = BYTE_W - CODE_W;

    logic              wel_q;
    logic [CODE_W-1:0] shut_q;

    // Set the latch on the key value; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) wel_q <= 1'b0;
        else if (wr_stb && wr_sel == SEL_STAT && wr_data == LATCH_KEY) wel_q <= 1'b1;
    end

    // Load the override code on a permitted shutdown write.
    always_ff @(posedge clk) begin
        if (!rst_n) shut_q <= '0;
        else if (wr_stb && wr_sel == SEL_SHUT && wel_q) shut_q <= wr_data[CODE_W-1:0];
    end

    assign wel       = wel_q;
    assign shut_code = shut_q;
    assign stat_byte = {{STAT_PAD{1'b0}}, gate_stat, wel_q};
    assign shut_byte = {{SHUT_PAD{1'b0}}, shut_q};

    // R6
    wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wel_q));

    // R7
    shut_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_q != $past(shut_q)) |-> $past(wel_q));
endmodule

// File: rtl/tw_engine.sv
// Bus protocol engine. It detects start and stop, shifts bytes in
// on SCL rise, and decides acknowledges and shifts read data out on
// SCL fall. Assumes synchronized bus inputs and one data byte per frame.
module tw_engine
    import tw_pkg::*;
#(
    parameter int STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  stat_byte,
    input  logic [BYTE_W-1:0]  shut_byte,
    input  logic               wel,
    output logic               wr_stb,
    output sel_t               wr_sel,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    phase_t            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic              in_ack;
    logic              rw_q;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] shreg, tx;
    sel_t              ptr;
    logic              scl_rise, scl_fall, start_det, stop_det, addr_match;
    logic [BYTE_W-1:0] rd_byte;

    assign scl_rise   = scl_s & ~scl_q;
    assign scl_fall   = ~scl_s & scl_q;
    assign start_det  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det   = scl_s & scl_q & ~sda_q & sda_s;
    assign addr_match = (shreg[BYTE_W-1 -: 4] == DEV_TYPE) && (shreg[STRAP_W:1] == strap);
    assign rd_byte    = (ptr == SEL_STAT) ? stat_byte :
                        (ptr == SEL_SHUT) ? shut_byte : '0;
    assign wr_sel     = ptr;
    assign wr_data    = shreg;

    // Main frame sequencer: edges, bit counting, acknowledge and read-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            rw_q   <= 1'b0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            shreg  <= '0;
            tx     <= '0;
            ptr    <= SEL_NONE;
            sda_oe <= 1'b0;
            wr_stb <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            scl_q  <= scl_s;
            sda_q  <= sda_s;
            if (start_det) begin
                phase  <= PH_DEV;
                bitcnt <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise && !in_ack && bitcnt < ACK_SLOT) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end else if (scl_fall) begin
                    if (bitcnt == ACK_SLOT && !in_ack) begin
                        in_ack <= 1'b1;
                        case (phase)
                            PH_DEV: begin
                                if (addr_match) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= shreg[0];
                                end else begin
                                    sda_oe <= 1'b0;
                                    phase  <= PH_IDLE;
                                end
                            end
                            PH_WORD: begin
                                sda_oe <= 1'b1;
                                ptr    <= (shreg == WA_STATUS) ? SEL_STAT :
                                          (shreg == WA_SHUT)   ? SEL_SHUT : SEL_NONE;
                            end
                            PH_WDATA: begin
                                if (ptr == SEL_SHUT && !wel) begin
                                    sda_oe <= 1'b0;
                                end else begin
                                    sda_oe <= 1'b1;
                                    wr_stb <= 1'b1;
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (in_ack) begin
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        case (phase)
                            PH_DEV: begin
                                if (rw_q) begin
                                    phase  <= PH_RDATA;
                                    tx     <= rd_byte;
                                    sda_oe <= ~rd_byte[BYTE_W-1];
                                end else begin
                                    phase  <= PH_WORD;
                                end
                            end
                            PH_WORD: phase <= PH_WDATA;
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (phase == PH_RDATA && bitcnt != '0) begin
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                    end
                end
            end
        end
    end

    // R10
    drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

    // R7
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ptr == SEL_SHUT) |-> wel);
endmodule

// File: rtl/tw_regslave.sv
// Top of the two-wire register slave. It joins the synchronizer, the
// protocol engine and the register pair. Assumes clk is well above SCL rate.
module tw_regslave #(
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 3,
    parameter int GATE_W      = 3,
    parameter int CODE_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [GATE_W-1:0]  gate_stat,
    output logic [CODE_W-1:0]  shut_code
);
    import tw_pkg::*;

    logic [1:0]        lines_s;
    logic              wr_stb, wel;
    sel_t              wr_sel;
    logic [BYTE_W-1:0] wr_data, stat_byte, shut_byte;

    tw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
    );

    tw_engine #(.STRAP_W(STRAP_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .strap(strap_addr), .stat_byte(stat_byte), .shut_byte(shut_byte),
        .wel(wel), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
        .sda_oe(sda_oe)
    );

    tw_regs #(.GATE_W(GATE_W), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .gate_stat(gate_stat), .wr_stb(wr_stb),
        .wr_sel(wr_sel), .wr_data(wr_data), .stat_byte(stat_byte),
        .shut_byte(shut_byte), .wel(wel), .shut_code(shut_code)
    );
endmodule

// File: tb/tw_regslave_test.sv
module tw_regslave_test;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'd0, gstat = 3'd0;
    logic       sda_oe;
    logic [1:0] shut_code;
    logic       sda_line;
    int checks = 0, fails = 0, viol = 0;
    logic prev_oe = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tw_regslave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_addr(strap), .gate_stat(gstat),
        .shut_code(shut_code)
    );

    // R10 monitor: drive changes must not happen while SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl_m) viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        ack = (sda_line == 1'b0);
        w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic wr_reg(input logic [7:0] wa, input logic [7:0] d,
                          output bit a0, output bit a1, output bit a2);
        bstart();
        send_byte({4'b1010, strap, 1'b0}, a0);
        send_byte(wa, a1);
        send_byte(d, a2);
        bstop();
    endtask

    task automatic rd_reg(input logic [7:0] wa, output logic [7:0] d, output bit allack);
        bit a0, a1, a2;
        bstart();
        send_byte({4'b1010, strap, 1'b0}, a0);
        send_byte(wa, a1);
        bstart();
        send_byte({4'b1010, strap, 1'b1}, a2);
        recv_byte(d);
        bstop();
        allack = a0 & a1 & a2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit a0, a1, a2, ok;
        logic [7:0] rd;
        w(5); rst_n = 1'b1; w(5);
        // R11 reset state
        chk(shut_code == 2'd0, "R11 shut_code", shut_code, 0);
        chk(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);

        // R1 traffic without a start is ignored
        scl_m = 1'b0; w(Q);
        send_byte({4'b1010, strap, 1'b0}, a0);
        chk(!a0, "R1 no ack without start", a0, 0);
        bstop();

        // R2 address sweep over strap and select bits
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                strap = 3'(s);
                bstart();
                send_byte({4'b1010, 3'(a), 1'b0}, a0);
                chk(a0 == (s == a), "R2 select match", a0, (s == a));
                bstop();
            end
        end
        strap = 3'd5;
        bstart();
        send_byte({4'b0110, strap, 1'b0}, a0);
        chk(!a0, "R2 wrong type code", a0, 0);
        bstop();
        chk(sda_oe == 1'b0, "R10 released after refused frame", sda_oe, 0);

        // R4 R9 status byte read over all gate patterns
        for (int g = 0; g < 8; g++) begin
            gstat = 3'(g);
            rd_reg(8'h00, rd, ok);
            chk(ok, "R3 acks in read", ok, 1);
            chk(rd == {4'b0, 3'(g), 1'b0}, "R4 status layout", rd, g * 2);
            chk(sda_oe == 1'b0, "R9 released after read", sda_oe, 0);
        end
        gstat = 3'b101;

        // R7 shutdown write refused while latch clear
        wr_reg(8'hFF, 8'h03, a0, a1, a2);
        chk(a0 && a1, "R3 address and word ack", {a0, a1}, 3);
        chk(!a2, "R7 data nack", a2, 0);
        chk(shut_code == 2'd0, "R7 code unchanged", shut_code, 0);
        rd_reg(8'hFF, rd, ok);
        chk(rd == 8'h00, "R7 readback", rd, 0);

        // R6 non-key status writes change nothing
        wr_reg(8'h00, 8'h03, a0, a1, a2);
        chk(a2, "R6 ack non-key 03", a2, 1);
        wr_reg(8'h00, 8'hFF, a0, a1, a2);
        chk(a2, "R6 ack non-key FF", a2, 1);
        wr_reg(8'h00, 8'h81, a0, a1, a2);
        rd_reg(8'h00, rd, ok);
        chk(rd == 8'h0A, "R6 latch still clear", rd, 8'h0A);

        // R5 key sets latch
        wr_reg(8'h00, 8'h01, a0, a1, a2);
        chk(a2, "R5 key ack", a2, 1);
        rd_reg(8'h00, rd, ok);
        chk(rd == 8'h0B, "R5 latch set", rd, 8'h0B);

        // R8 shutdown writes with latch set, junk in upper bits
        for (int c = 0; c < 4; c++) begin
            wr_reg(8'hFF, 8'hA4 | 8'(c), a0, a1, a2);
            chk(a2, "R8 data ack", a2, 1);
            chk(shut_code == 2'(c), "R8 code loaded", shut_code, c);
            rd_reg(8'hFF, rd, ok);
            chk(rd == 8'(c), "R8 readback", rd, c);
        end
        wr_reg(8'hFF, 8'h02, a0, a1, a2);

        // R6 latch survives a zero write
        wr_reg(8'h00, 8'h00, a0, a1, a2);
        rd_reg(8'h00, rd, ok);
        chk(rd == 8'h0B, "R6 latch kept", rd, 8'h0B);
        chk(shut_code == 2'd2, "R6 code kept", shut_code, 2);

        chk(viol == 0, "R10 drive change while SCL high", viol, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule